// File: doc/BRIEF.md
# Control Word Decoder with Configuration Registers

This block sits behind a byte-wide link receiver that has already packed incoming bytes into 32-bit words. Each accepted word carries a four-bit selector in bits 31:28 and a 28-bit payload below it. Selectors 0 to 3 store the payload in one of four configuration registers: sampling-clock setup, trigger/routing, channel pair C/D mode and decimation, and channel pair A/B mode and decimation. Two further selectors are actions instead of storage. One performs a global reset of the configuration. The other fires a one-cycle load strobe that pushes the clock setup register into the serial clock synthesizers.

After reset, and again after every global-reset command, the sender must open with one dummy word. The block discards that word and sends back a single firmware identity word. The reply has the form 0xFF364F followed by one major and one minor version digit. It is offered on a valid/ready pair and held until taken. Only then are command words decoded. The trigger/routing register is also broken out into per-pair trigger enable and trigger polarity outputs.

Top module: `cwd_top`

## Requirements
- R1: During and after reset the four registers hold their parameter defaults (clock 0x000A5C, routing 0x0000000, C/D 0x0000001, A/B 0x0000001 by default). in_ready is 1, and reply_valid, sys_rst and synth_load are 0.
- R2: In the wait-for-dummy state the first accepted word is discarded whatever its value, a value with selector 0xD or 0xF included. One cycle later reply_valid is 1 and reply_word is {0xFF364F, VER_MAJOR, VER_MINOR}, which is 0xFF364F13 by default.
- R3: While reply_valid is 1, reply_word stays stable and in_ready is 0. A cycle with reply_ready at 1 ends the reply, and from the next cycle in_ready is 1.
- R4: After the handshake, an accepted word with selector 0, 1, 2 or 3 writes bits 27:0 into the clock, routing, C/D or A/B register respectively. The new value shows one cycle after acceptance.
- R5: The trigger outputs come from the routing register. Bit 0 is the A/B enable and bit 1 the A/B polarity (1 means active high). Bit 4 is the C/D enable and bit 5 the C/D polarity.
- R6: An accepted word with selector 0xD returns every register to its default one cycle later. It also drives sys_rst high for exactly RST_CYCLES cycles (4 by default), with in_ready at 0 throughout.
- R7: When the reset pulse ends, the block is again in the wait-for-dummy state, so the next word is treated as a dummy under R2.
- R8: An accepted word with selector 0xF drives synth_load high for exactly one cycle, starting one cycle after acceptance. Its 28 payload bits are ignored and no register changes.
- R9: Accepted words with selectors 0x4 to 0xC or 0xE change no register and raise neither pulse.
- R10: A word offered while in_ready is 0 is not taken and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Assembled word available |
| in_word | input | 32 | Assembled control word |
| in_ready | output | 1 | Block accepts a word this cycle |
| reply_valid | output | 1 | Identity word on offer |
| reply_ready | input | 1 | Transmit side takes the identity word |
| reply_word | output | 32 | Identity word |
| clk_cfg | output | 28 | Clock setup register |
| route_cfg | output | 28 | Trigger and routing register |
| cd_cfg | output | 28 | Channel C/D mode and decimation register |
| ab_cfg | output | 28 | Channel A/B mode and decimation register |
| trig_ab_en | output | 1 | A/B trigger enable |
| trig_ab_hi | output | 1 | A/B trigger active high |
| trig_cd_en | output | 1 | C/D trigger enable |
| trig_cd_hi | output | 1 | C/D trigger active high |
| sys_rst | output | 1 | Global reset pulse |
| synth_load | output | 1 | Serial synthesizer load strobe |

## Verification
The hardest situation to reach is a word arriving while the block is not listening. One case is a word offered while the identity reply waits for reply_ready. Another is an action selector arriving as the dummy right after a global reset. The stimulus reaches both on purpose. Each handshake holds reply_ready low for a random number of cycles and offers a register write in the meantime. The random command mix includes global resets, so the word that follows is the dummy and often carries a random selector. A directed step also sends 0xD itself as the first dummy.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 4;
    localparam int PAY_W  = WORD_W - SEL_W;
    localparam int NREG   = 4;

    localparam logic [SEL_W-1:0] SEL_GRST  = 4'hD;
    localparam logic [SEL_W-1:0] SEL_SLOAD = 4'hF;

    // values 0..NREG-1 name the storage registers
    typedef enum logic [2:0] {
        K_REG0  = 3'd0,
        K_REG1  = 3'd1,
        K_REG2  = 3'd2,
        K_REG3  = 3'd3,
        K_GRST  = 3'd4,
        K_SLOAD = 3'd5,
        K_NONE  = 3'd6
    } kind_t;

    typedef enum logic [1:0] {
        S_WAIT  = 2'd0,
        S_REPLY = 2'd1,
        S_RUN   = 2'd2,
        S_RST   = 2'd3
    } st_t;

    typedef logic [NREG-1:0][PAY_W-1:0] cfg_arr_t;
endpackage

// File: rtl/cwd_decode.sv
module cwd_decode
    import cwd_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output kind_t            kind
);
    always_comb begin
        kind = K_NONE;
        if (sel == SEL_GRST) begin
            kind = K_GRST;
        end else if (sel == SEL_SLOAD) begin
            kind = K_SLOAD;
        end else if (int'(sel) < NREG) begin
            kind = kind_t'(sel[2:0]);
        end
    end
endmodule

// File: rtl/cwd_fsm.sv
module cwd_fsm
    import cwd_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  kind_t kind,
    input  logic  reply_ready,
    output logic  in_ready,
    output logic  reply_valid,
    output logic  wr_en,
    output logic  clr,
    output logic  sys_rst,
    output logic  synth_load
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        st_t           st;
        logic [CW-1:0] cnt;
        logic          reply_v;
        logic          rst_p;
        logic          load_p;
    } fsm_t;

    fsm_t q, d;
    logic acc;

    assign in_ready = (q.st == S_WAIT) || (q.st == S_RUN);
    assign acc      = in_valid && in_ready;

    always_comb begin
        d        = q;
        d.load_p = 1'b0;
        case (q.st)
            S_WAIT: begin
                if (acc) begin
                    d.st      = S_REPLY;
                    d.reply_v = 1'b1;
                end
            end
            S_REPLY: begin
                if (reply_ready) begin
                    d.st      = S_RUN;
                    d.reply_v = 1'b0;
                end
            end
            S_RUN: begin
                if (acc) begin
                    if (kind == K_GRST) begin
                        d.st    = S_RST;
                        d.cnt   = CW'(RST_CYCLES - 1);
                        d.rst_p = 1'b1;
                    end else if (kind == K_SLOAD) begin
                        d.load_p = 1'b1;
                    end
                end
            end
            S_RST: begin
                if (q.cnt == '0) begin
                    d.st    = S_WAIT;
                    d.rst_p = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = S_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_WAIT, cnt: '0, reply_v: 1'b0, rst_p: 1'b0, load_p: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_en       = acc && (q.st == S_RUN);
    assign clr         = wr_en && (kind == K_GRST);
    assign reply_valid = q.reply_v;
    assign sys_rst     = q.rst_p;
    assign synth_load  = q.load_p;
endmodule

// File: rtl/cwd_regs.sv
module cwd_regs
    import cwd_pkg::*;
#(
    parameter cfg_arr_t DEFAULTS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             clr,
    input  kind_t            kind,
    input  logic [PAY_W-1:0] payload,
    output cfg_arr_t         cfg
);
    typedef struct packed {
        cfg_arr_t cfg;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cfg = DEFAULTS;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_en && (int'(kind) == i)) begin
                    d.cfg[i] = payload;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cfg: DEFAULTS};
        end else begin
            q <= d;
        end
    end

    assign cfg = q.cfg;
endmodule

// File: rtl/cwd_top.sv
module cwd_top
    import cwd_pkg::*;
#(
    parameter logic [3:0]       VER_MAJOR  = 4'h1,
    parameter logic [3:0]       VER_MINOR  = 4'h3,
    parameter int               RST_CYCLES = 4,
    parameter logic [PAY_W-1:0] DEF_CLK    = 28'h000_0A5C,
    parameter logic [PAY_W-1:0] DEF_ROUTE  = 28'h000_0000,
    parameter logic [PAY_W-1:0] DEF_CD     = 28'h000_0001,
    parameter logic [PAY_W-1:0] DEF_AB     = 28'h000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              reply_valid,
    input  logic              reply_ready,
    output logic [WORD_W-1:0] reply_word,
    output logic [PAY_W-1:0]  clk_cfg,
    output logic [PAY_W-1:0]  route_cfg,
    output logic [PAY_W-1:0]  cd_cfg,
    output logic [PAY_W-1:0]  ab_cfg,
    output logic              trig_ab_en,
    output logic              trig_ab_hi,
    output logic              trig_cd_en,
    output logic              trig_cd_hi,
    output logic              sys_rst,
    output logic              synth_load
);
    localparam cfg_arr_t DEFAULTS = {DEF_AB, DEF_CD, DEF_ROUTE, DEF_CLK};
    localparam logic [WORD_W-1:0] ID_WORD = {24'hFF364F, VER_MAJOR, VER_MINOR};

    kind_t    kind;
    logic     wr_en;
    logic     clr;
    cfg_arr_t cfg;

    cwd_decode u_dec (
        .sel  (in_word[WORD_W-1 -: SEL_W]),
        .kind (kind)
    );

    cwd_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .kind        (kind),
        .reply_ready (reply_ready),
        .in_ready    (in_ready),
        .reply_valid (reply_valid),
        .wr_en       (wr_en),
        .clr         (clr),
        .sys_rst     (sys_rst),
        .synth_load  (synth_load)
    );

    cwd_regs #(.DEFAULTS(DEFAULTS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr     (clr),
        .kind    (kind),
        .payload (in_word[PAY_W-1:0]),
        .cfg     (cfg)
    );

    assign reply_word = ID_WORD;
    assign clk_cfg    = cfg[0];
    assign route_cfg  = cfg[1];
    assign cd_cfg     = cfg[2];
    assign ab_cfg     = cfg[3];
    assign trig_ab_en = route_cfg[0];
    assign trig_ab_hi = route_cfg[1];
    assign trig_cd_en = route_cfg[4];
    assign trig_cd_hi = route_cfg[5];
endmodule

// File: rtl/cwd_chk.sv
module cwd_chk #(
    parameter logic [31:0] ID_WORD   = 32'h0,
    parameter logic [27:0] DEF_CLK   = 28'h0,
    parameter logic [27:0] DEF_ROUTE = 28'h0,
    parameter logic [27:0] DEF_CD    = 28'h0,
    parameter logic [27:0] DEF_AB    = 28'h0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        in_ready,
    input logic        reply_valid,
    input logic        reply_ready,
    input logic [31:0] reply_word,
    input logic [27:0] clk_cfg,
    input logic [27:0] route_cfg,
    input logic [27:0] cd_cfg,
    input logic [27:0] ab_cfg,
    input logic        sys_rst,
    input logic        synth_load
);
    logic       primed_q;
    logic       acc;
    logic [3:0] sel;
    logic       unassigned;

    assign acc        = in_valid && in_ready;
    assign sel        = in_word[31:28];
    assign unassigned = (sel >= 4'h4) && (sel != 4'hD) && (sel != 4'hF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      primed_q <= 1'b0;
        else if (sys_rst)                primed_q <= 1'b0;
        else if (reply_valid && reply_ready) primed_q <= 1'b1;
    end

    // R2
    dummy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!primed_q && acc) |=> (reply_valid && reply_word == ID_WORD
                                && $stable(clk_cfg) && $stable(route_cfg)));

    // R3
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid && !reply_ready) |=> (reply_valid && $stable(reply_word)));

    // R3
    reply_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> !in_ready);

    // R6
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && acc && sel == 4'hD) |=> (sys_rst && clk_cfg == DEF_CLK
            && route_cfg == DEF_ROUTE && cd_cfg == DEF_CD && ab_cfg == DEF_AB));

    // R6
    rst_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> !in_ready);

    // R8
    load_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && acc && sel == 4'hF) |=> (synth_load && $stable(clk_cfg) && $stable(ab_cfg)));

    // R8
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synth_load |=> !synth_load);

    // R9
    unassigned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && unassigned) |=> ($stable(clk_cfg) && $stable(route_cfg) && $stable(cd_cfg)
                                 && $stable(ab_cfg) && !synth_load && !sys_rst));

    // R10
    refused_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> ($stable(clk_cfg) && $stable(route_cfg)
                                     && $stable(cd_cfg) && $stable(ab_cfg)));
endmodule

bind cwd_top cwd_chk #(
    .ID_WORD   ({24'hFF364F, VER_MAJOR, VER_MINOR}),
    .DEF_CLK   (DEF_CLK),
    .DEF_ROUTE (DEF_ROUTE),
    .DEF_CD    (DEF_CD),
    .DEF_AB    (DEF_AB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_ready    (in_ready),
    .reply_valid (reply_valid),
    .reply_ready (reply_ready),
    .reply_word  (reply_word),
    .clk_cfg     (clk_cfg),
    .route_cfg   (route_cfg),
    .cd_cfg      (cd_cfg),
    .ab_cfg      (ab_cfg),
    .sys_rst     (sys_rst),
    .synth_load  (synth_load)
);

// File: tb/tb_cwd_top.sv
module tb_cwd_top;
    localparam int          RSTC   = 4;
    localparam logic [31:0] ID_EXP = 32'hFF364F13;
    localparam logic [27:0] DEFV [4] = '{28'h000_0A5C, 28'h0, 28'h1, 28'h1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        reply_ready = 1'b0;
    logic        in_ready, reply_valid, sys_rst, synth_load;
    logic [31:0] reply_word;
    logic [27:0] clk_cfg, route_cfg, cd_cfg, ab_cfg;
    logic        trig_ab_en, trig_ab_hi, trig_cd_en, trig_cd_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [27:0] exp_cfg [4];
    bit primed = 1'b0;

    always #2.5 clk = ~clk;

    cwd_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .reply_valid(reply_valid), .reply_ready(reply_ready),
        .reply_word(reply_word), .clk_cfg(clk_cfg), .route_cfg(route_cfg),
        .cd_cfg(cd_cfg), .ab_cfg(ab_cfg), .trig_ab_en(trig_ab_en),
        .trig_ab_hi(trig_ab_hi), .trig_cd_en(trig_cd_en), .trig_cd_hi(trig_cd_hi),
        .sys_rst(sys_rst), .synth_load(synth_load)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] got(input int i);
        case (i)
            0: return clk_cfg;
            1: return route_cfg;
            2: return cd_cfg;
            default: return ab_cfg;
        endcase
    endfunction

    task automatic chk_regs(input string req);
        for (int i = 0; i < 4; i++) chk(got(i) === exp_cfg[i], req, {4'h0, got(i)}, {4'h0, exp_cfg[i]});
        // R5 trigger field positions
        chk({trig_cd_hi, trig_cd_en, trig_ab_hi, trig_ab_en} ===
            {exp_cfg[1][5], exp_cfg[1][4], exp_cfg[1][1], exp_cfg[1][0]}, "R5",
            {28'h0, trig_cd_hi, trig_cd_en, trig_ab_hi, trig_ab_en},
            {28'h0, exp_cfg[1][5], exp_cfg[1][4], exp_cfg[1][1], exp_cfg[1][0]});
    endtask

    task automatic handshake(input int delay);
        for (int k = 0; k < delay; k++) begin
            // R10: write attempt while the reply is pending
            in_valid = 1'b1;
            in_word  = {4'($urandom % 4), 28'($urandom)};
            @(negedge clk);
            in_valid = 1'b0;
            chk(reply_valid === 1'b1 && reply_word === ID_EXP, "R3", reply_word, ID_EXP);
            chk(in_ready === 1'b0, "R3", {31'h0, in_ready}, 32'h0);
            chk_regs("R10");
        end
        reply_ready = 1'b1;
        @(negedge clk);
        reply_ready = 1'b0;
        chk(reply_valid === 1'b0 && in_ready === 1'b1, "R3",
            {30'h0, reply_valid, in_ready}, 32'h1);
        primed = 1'b1;
    endtask

    task automatic send(input logic [31:0] w, input int hs_delay);
        @(negedge clk);
        chk(in_ready === 1'b1, "R3", {31'h0, in_ready}, 32'h1);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        if (!primed) begin
            chk(reply_valid === 1'b1 && reply_word === ID_EXP, "R2", reply_word, ID_EXP);
            chk(sys_rst === 1'b0 && synth_load === 1'b0, "R2", {30'h0, sys_rst, synth_load}, 32'h0);
            chk_regs("R2");
            handshake(hs_delay);
        end else begin
            case (w[31:28])
                4'h0, 4'h1, 4'h2, 4'h3: begin
                    exp_cfg[w[29:28]] = w[27:0];
                    chk_regs("R4");
                end
                4'hD: begin
                    int n;
                    for (int i = 0; i < 4; i++) exp_cfg[i] = DEFV[i];
                    chk_regs("R6");
                    n = 0;
                    while (sys_rst === 1'b1 && n < 100) begin
                        chk(in_ready === 1'b0, "R6", {31'h0, in_ready}, 32'h0);
                        n++;
                        @(negedge clk);
                    end
                    chk(n == RSTC, "R6", n, RSTC);
                    // R7: next word must be a dummy again
                    primed = 1'b0;
                    chk(in_ready === 1'b1 && reply_valid === 1'b0, "R7",
                        {30'h0, in_ready, reply_valid}, 32'h2);
                end
                4'hF: begin
                    chk(synth_load === 1'b1, "R8", {31'h0, synth_load}, 32'h1);
                    chk_regs("R8");
                    @(negedge clk);
                    chk(synth_load === 1'b0, "R8", {31'h0, synth_load}, 32'h0);
                end
                default: begin
                    chk(synth_load === 1'b0 && sys_rst === 1'b0, "R9",
                        {30'h0, synth_load, sys_rst}, 32'h0);
                    chk_regs("R9");
                end
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) exp_cfg[i] = DEFV[i];
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk_regs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_regs("R1");
        chk(in_ready === 1'b1 && reply_valid === 1'b0 && sys_rst === 1'b0 && synth_load === 1'b0,
            "R1", {28'h0, in_ready, reply_valid, sys_rst, synth_load}, 32'h8);

        // directed: a reset selector as dummy is just a dummy (R2)
        send(32'hD123_4567, 3);
        send(32'h0ABC_DEF0, 0);
        send(32'h1000_0033, 0);
        send(32'h1000_0012, 0);
        send(32'h2765_4321, 0);
        send(32'h3FFF_FFFF, 0);
        send(32'hFFFF_FFFF, 0);
        send(32'hE123_4567, 0);
        send(32'h4000_0001, 0);
        send(32'hC000_0001, 0);
        send(32'hD000_0000, 0);
        send(32'hF000_0000, 1);   // dummy after reset, action selector ignored
        send(32'h1000_0021, 0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r;
            logic [3:0] s;
            r = int'($urandom % 20);
            if (r < 12)       s = 4'(r % 4);
            else if (r < 14)  s = 4'hF;
            else if (r == 14) s = 4'hD;
            else              s = 4'($urandom);
            send({s, 28'($urandom)}, int'($urandom % 4));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule